// File: doc/BRIEF.md
# Synthesizer Tuning Word Control Port

This block is the write side of a two-wire serial slave that programs a PLL tuning synthesizer. It watches already-synchronized clock and data lines, recognises START and STOP conditions, and compares each address byte with a device identity. Five of the identity bits are fixed. The remaining two come from a strap input, so several synthesizers can share one bus. After a matching write address, the block pulls the data line low during the ninth clock of every byte. The data bytes it receives are then sorted into three latches: a 15-bit divider ratio, a 7-bit control word and an 8-bit port word.

A data byte whose top bit is 0 opens a frequency pair. Its low seven bits are staged as the upper part of the divider, and the next byte supplies the lower eight bits. The divider latch changes only once that second byte has been acknowledged. A data byte whose top bit is 1 opens a control pair. Its low seven bits go straight to the control word, and the next byte is the port word. Once a pair is complete, the top bit of the following byte is examined again. A single transfer can therefore update everything, or it can repeat frequency pairs for a smooth sweep, with no re-addressing until STOP.

Top module: `tsyn_ctl`

## Requirements
- R1: After reset the divider latch, every control field and all eight port bits are 0. For the port word this means the open-collector style outputs are off and the follower style outputs are active.
- R2: An address byte is acknowledged only when bits 7..3 equal the identity parameter (default 11000b), bits 2..1 equal `addr_strap_i`, and bit 0 (the read/write bit) is 0. Any other address gets no acknowledge, and no latch changes before the next START.
- R3: After a matching address, every data byte is acknowledged.
- R4: A data byte with bit 7 = 0 stages its bits 6..0 as divider bits 14..8. The following byte supplies divider bits 7..0. `div_ratio_o` is unchanged until that second byte is acknowledged, and then all 15 bits change together.
- R5: A data byte with bit 7 = 1 loads the control word as follows: bit 6 pump current high, bit 5 divider test output, bit 4 pump tristate, bit 3 band source select, bits 2..1 band code, bit 0 tuning drive off. The following byte loads `port_o` bit for bit, except that port bit 3 is don't-care and is always stored as 0.
- R6: After the second byte of either pair, the next byte's bit 7 selects the pair again. This repeats until STOP with no new address byte.
- R7: A STOP before the ninth clock rising edge of a byte leaves every latch unchanged. A STOP between the two bytes of a frequency pair leaves the divider unchanged, and the next transfer starts a fresh pair selection.
- R8: A repeated START abandons the current byte and restarts address matching.
- R9: `sda_pull_o` rises only while SCL is low, after the eighth rising edge of an acknowledged byte. It falls at the SCL falling edge that follows the ninth clock.
- R10: The latches change only at the ninth SCL rising edge of a byte, and a divider update never coincides with a control or port update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data (resolved bus level) |
| addr_strap_i | input | 2 | Programmable low address bits |
| sda_pull_o | output | 1 | Drive the data line low (acknowledge) |
| div_ratio_o | output | 15 | Divider ratio latch |
| pump_hi_o | output | 1 | Charge pump high current select |
| test_div_out_o | output | 1 | Test: route divider output to a port |
| pump_tristate_o | output | 1 | Test: charge pump output off |
| band_from_port_o | output | 1 | Band output taken from port bits instead of band code |
| band_code_o | output | 2 | Band code |
| tuning_drive_off_o | output | 1 | Disable the tuning voltage amplifier |
| port_o | output | 8 | Port latch (bit 3 always 0) |

## Verification
Some properties are checked on every cycle. The acknowledge drive may only rise while SCL is low. Each latch may only change one cycle after an SCL rising edge. A divider update never lands in the same cycle as a control or port update. The bench has to show the rest through scenarios. These are: which address bytes are acknowledged under each strap value, the exact bit placement of the divider, control and port fields, the staging of the upper divider half, the reselection of pairs within one long transfer, and the fact that a STOP or repeated START in mid-byte leaves the latches alone.

// File: rtl/tsyn_pkg.sv
package tsyn_pkg;
    localparam int BYTE_W  = 8;
    localparam int STRAP_W = 2;
    localparam int ID_W    = BYTE_W - 1 - STRAP_W;
    localparam int DIV_W   = 2 * BYTE_W - 1;
    localparam int HI_W    = BYTE_W - 1;
    localparam int PORT_DC = 3;

    typedef enum logic [1:0] {
        PH_ADDR    = 2'd0,
        PH_SELECT  = 2'd1,
        PH_FREQ_LO = 2'd2,
        PH_PORT    = 2'd3
    } phase_e;

    typedef struct packed {
        logic       pump_hi;
        logic       tst_div;
        logic       tst_tri;
        logic       band_src;
        logic [1:0] band;
        logic       drv_off;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '0;
    localparam logic [BYTE_W-1:0] PORT_RST = '0;
endpackage

// File: rtl/tsyn_bus_cond.sv
module tsyn_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } smp_t;

    smp_t st_d, st_q;

    always_comb begin
        st_d.scl = scl_i;
        st_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign scl_rise_o = scl_i & ~st_q.scl;
    assign scl_fall_o = ~scl_i & st_q.scl;
    assign start_o    = scl_i & st_q.scl & st_q.sda & ~sda_i;
    assign stop_o     = scl_i & st_q.scl & ~st_q.sda & sda_i;
endmodule

// File: rtl/tsyn_byte_rx.sv
module tsyn_byte_rx
    import tsyn_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sda_i,
    input  logic         scl_rise_i,
    input  logic         scl_fall_i,
    input  logic         start_i,
    input  logic         stop_i,
    input  logic         ack_req_i,
    output logic [W-1:0] rx_byte_o,
    output logic         ack_strobe_o,
    output logic         sda_pull_o
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        logic             active;
        logic             full;
        logic             in_ack;
        logic             drive;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     sh;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (stop_i) begin
            rx_d.active = 1'b0;
            rx_d.full   = 1'b0;
            rx_d.in_ack = 1'b0;
            rx_d.drive  = 1'b0;
            rx_d.cnt    = '0;
        end else if (start_i) begin
            rx_d.active = 1'b1;
            rx_d.full   = 1'b0;
            rx_d.in_ack = 1'b0;
            rx_d.drive  = 1'b0;
            rx_d.cnt    = '0;
        end else if (rx_q.active) begin
            if (scl_rise_i && !rx_q.full && !rx_q.in_ack) begin
                rx_d.sh = {rx_q.sh[W-2:0], sda_i};
                if (rx_q.cnt == LAST) begin
                    rx_d.full = 1'b1;
                    rx_d.cnt  = '0;
                end else begin
                    rx_d.cnt = rx_q.cnt + CNT_W'(1);
                end
            end
            if (scl_fall_i && rx_q.full) begin
                rx_d.full = 1'b0;
                if (ack_req_i) begin
                    rx_d.in_ack = 1'b1;
                    rx_d.drive  = 1'b1;
                end else begin
                    rx_d.active = 1'b0;
                end
            end
            if (scl_fall_i && rx_q.in_ack) begin
                rx_d.in_ack = 1'b0;
                rx_d.drive  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rx_byte_o    = rx_q.sh;
    assign ack_strobe_o = rx_q.active & rx_q.in_ack & scl_rise_i;
    assign sda_pull_o   = rx_q.drive;
endmodule

// File: rtl/tsyn_reg_dec.sv
module tsyn_reg_dec
    import tsyn_pkg::*;
#(
    parameter logic [ID_W-1:0] DEV_ID = 5'b11000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               ack_strobe_i,
    input  logic [BYTE_W-1:0]  rx_byte_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               ack_req_o,
    output logic [DIV_W-1:0]   div_o,
    output ctrl_t              ctrl_o,
    output logic [BYTE_W-1:0]  port_o
);
    localparam logic [BYTE_W-1:0] PORT_MASK = ~(BYTE_W'(1) << PORT_DC);

    typedef struct packed {
        phase_e            phase;
        logic [HI_W-1:0]   hi;
        logic [DIV_W-1:0]  div;
        ctrl_t             ctrl;
        logic [BYTE_W-1:0] port;
    } dec_t;

    dec_t dc_d, dc_q;
    logic addr_hit;

    always_comb begin
        addr_hit  = (rx_byte_i[BYTE_W-1:1] == {DEV_ID, strap_i}) && !rx_byte_i[0];
        ack_req_o = (dc_q.phase == PH_ADDR) ? addr_hit : 1'b1;
    end

    always_comb begin
        dc_d = dc_q;
        if (start_i || stop_i) begin
            dc_d.phase = PH_ADDR;
        end else if (ack_strobe_i) begin
            unique case (dc_q.phase)
                PH_ADDR: dc_d.phase = PH_SELECT;
                PH_SELECT: begin
                    if (rx_byte_i[BYTE_W-1]) begin
                        dc_d.ctrl  = ctrl_t'(rx_byte_i[HI_W-1:0]);
                        dc_d.phase = PH_PORT;
                    end else begin
                        dc_d.hi    = rx_byte_i[HI_W-1:0];
                        dc_d.phase = PH_FREQ_LO;
                    end
                end
                PH_FREQ_LO: begin
                    dc_d.div   = {dc_q.hi, rx_byte_i};
                    dc_d.phase = PH_SELECT;
                end
                PH_PORT: begin
                    dc_d.port  = rx_byte_i & PORT_MASK;
                    dc_d.phase = PH_SELECT;
                end
                default: dc_d.phase = PH_ADDR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc_q.phase <= PH_ADDR;
            dc_q.hi    <= '0;
            dc_q.div   <= '0;
            dc_q.ctrl  <= CTRL_RST;
            dc_q.port  <= PORT_RST;
        end else begin
            dc_q <= dc_d;
        end
    end

    assign div_o  = dc_q.div;
    assign ctrl_o = dc_q.ctrl;
    assign port_o = dc_q.port;
endmodule

// File: rtl/tsyn_ctl.sv
module tsyn_ctl
    import tsyn_pkg::*;
#(
    parameter logic [ID_W-1:0] DEV_ID = 5'b11000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] addr_strap_i,
    output logic               sda_pull_o,
    output logic [DIV_W-1:0]   div_ratio_o,
    output logic               pump_hi_o,
    output logic               test_div_out_o,
    output logic               pump_tristate_o,
    output logic               band_from_port_o,
    output logic [1:0]         band_code_o,
    output logic               tuning_drive_off_o,
    output logic [BYTE_W-1:0]  port_o
);
    logic              scl_rise, scl_fall, start_c, stop_c;
    logic              ack_req, ack_strobe;
    logic [BYTE_W-1:0] rx_byte;
    ctrl_t             ctrl;

    tsyn_bus_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    tsyn_byte_rx #(.W(BYTE_W)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_i        (sda_i),
        .scl_rise_i   (scl_rise),
        .scl_fall_i   (scl_fall),
        .start_i      (start_c),
        .stop_i       (stop_c),
        .ack_req_i    (ack_req),
        .rx_byte_o    (rx_byte),
        .ack_strobe_o (ack_strobe),
        .sda_pull_o   (sda_pull_o)
    );

    tsyn_reg_dec #(.DEV_ID(DEV_ID)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_c),
        .stop_i       (stop_c),
        .ack_strobe_i (ack_strobe),
        .rx_byte_i    (rx_byte),
        .strap_i      (addr_strap_i),
        .ack_req_o    (ack_req),
        .div_o        (div_ratio_o),
        .ctrl_o       (ctrl),
        .port_o       (port_o)
    );

    assign pump_hi_o          = ctrl.pump_hi;
    assign test_div_out_o     = ctrl.tst_div;
    assign pump_tristate_o    = ctrl.tst_tri;
    assign band_from_port_o   = ctrl.band_src;
    assign band_code_o        = ctrl.band;
    assign tuning_drive_off_o = ctrl.drv_off;
endmodule

// File: rtl/tsyn_ctl_chk.sv
module tsyn_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_pull_o,
    input logic [14:0] div_ratio_o,
    input logic [6:0]  ctrl_v,
    input logic [7:0]  port_o
);
    p_pull_rise_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !$past(scl_i));

    p_div_at_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_ratio_o) |-> ($past(scl_i) && !$past(scl_i, 2)));

    p_ctrl_at_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_v) |-> ($past(scl_i) && !$past(scl_i, 2)));

    p_port_at_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port_o) |-> ($past(scl_i) && !$past(scl_i, 2)));

    p_div_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_ratio_o) |-> ($stable(ctrl_v) && $stable(port_o)));

    p_port_dc_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !port_o[3]);
endmodule

bind tsyn_ctl tsyn_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_pull_o  (sda_pull_o),
    .div_ratio_o (div_ratio_o),
    .ctrl_v      ({pump_hi_o, test_div_out_o, pump_tristate_o, band_from_port_o,
                   band_code_o, tuning_drive_off_o}),
    .port_o      (port_o)
);

// File: tb/sim_tsyn_ctl.sv
`timescale 1ns/1ps
module sim_tsyn_ctl;
    localparam int W = 2;
    localparam int LIMIT = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic sda_pull;
    logic [14:0] div_ratio;
    logic pump_hi, tdiv, ttri, bsrc, doff;
    logic [1:0] band;
    logic [7:0] port;
    wire  sda_bus = sda_m & ~sda_pull;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic ak, tok;

    always #4 clk = ~clk;

    tsyn_ctl u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_strap_i(strap), .sda_pull_o(sda_pull), .div_ratio_o(div_ratio),
        .pump_hi_o(pump_hi), .test_div_out_o(tdiv), .pump_tristate_o(ttri),
        .band_from_port_o(bsrc), .band_code_o(band), .tuning_drive_off_o(doff),
        .port_o(port)
    );

    function automatic logic [6:0] ctrl_now();
        return {pump_hi, tdiv, ttri, bsrc, band, doff};
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(W);
        scl_m = 1'b1; tick(W);
        sda_m = 1'b0; tick(W);
        scl_m = 1'b0; tick(W);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(W);
        scl_m = 1'b1; tick(W);
        sda_m = 1'b1; tick(W);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(W);
            scl_m = 1'b1; tick(W);
            if (sda_pull) tok = 1'b0;
            scl_m = 1'b0; tick(W);
        end
    endtask

    task automatic send_byte(logic [7:0] b);
        tok = 1'b1;
        send_bits(b, 8);
        sda_m = 1'b1; tick(W);
        scl_m = 1'b1; tick(W);
        ak = (sda_bus == 1'b0);
        scl_m = 1'b0; tick(W);
        if (sda_pull) tok = 1'b0;
    endtask

    logic [6:0]  exp_ctrl;
    logic [7:0]  exp_port;
    logic [14:0] exp_div;

    task automatic put_ctrl(logic [7:0] adr, logic [6:0] c, logic [7:0] p);
        bus_start();
        send_byte(adr);       chk(ak == 1'b1, "R2 address ack", ak, 1);
        send_byte({1'b1, c}); chk(ak == 1'b1, "R3 control ack", ak, 1);
        chk(ctrl_now() == c, "R5 control fields", ctrl_now(), c);
        send_byte(p);         chk(ak == 1'b1, "R3 port ack", ak, 1);
        chk(port == (p & 8'hF7), "R5 port bits with bit3 cleared", port, p & 8'hF7);
        chk(tok == 1'b1, "R9 ack window", tok, 1);
        bus_stop();
        exp_ctrl = c;
        exp_port = p & 8'hF7;
    endtask

    task automatic put_freq(logic [14:0] v);
        send_byte({1'b0, v[14:8]}); chk(ak == 1'b1, "R3 freq hi ack", ak, 1);
        chk(div_ratio == exp_div, "R4 divider held after upper byte", div_ratio, exp_div);
        send_byte(v[7:0]);          chk(ak == 1'b1, "R3 freq lo ack", ak, 1);
        chk(div_ratio == v, "R4 divider after lower byte", div_ratio, v);
        exp_div = v;
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R6 act=%0d exp=%0d", LIMIT, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state
        chk(div_ratio == 15'd0, "R1 divider reset", div_ratio, 0);
        chk(ctrl_now() == 7'd0, "R1 control reset", ctrl_now(), 0);
        chk(port == 8'd0, "R1 port reset", port, 0);
        chk(sda_pull == 1'b0, "R1 no pull at reset", sda_pull, 0);
        exp_ctrl = '0; exp_port = '0; exp_div = '0;

        // R2 sweep of every address byte with strap 10
        strap = 2'b10;
        for (int a = 0; a < 256; a++) begin
            logic [6:0] pay;
            bit hit;
            pay = 7'((a * 5 + 1) & 8'h7F);
            hit = (a == 8'hC4);
            bus_start();
            send_byte(8'(a));
            chk(ak == hit, "R2 address sweep ack", ak, hit);
            chk(tok == 1'b1, "R9 pull only in ninth clock", tok, 1);
            send_byte({1'b1, pay});
            chk(ak == hit, "R3 data ack follows address match", ak, hit);
            bus_stop();
            if (hit) exp_ctrl = pay;
            chk(ctrl_now() == exp_ctrl, "R2 control only after match", ctrl_now(), exp_ctrl);
        end

        // R2 strap values against the four candidate identities
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            for (int j = 0; j < 4; j++) begin
                logic [6:0] pay;
                bit hit;
                pay = 7'(s * 16 + j * 3 + 1);
                hit = (j == s);
                bus_start();
                send_byte({5'b11000, 2'(j), 1'b0});
                chk(ak == hit, "R2 strap match", ak, hit);
                send_byte({1'b1, pay});
                bus_stop();
                if (hit) exp_ctrl = pay;
                chk(ctrl_now() == exp_ctrl, "R2 strap control", ctrl_now(), exp_ctrl);
            end
        end

        // R4 divider sweep, strap 01
        strap = 2'b01;
        for (int k = 0; k < 48; k++) begin
            logic [14:0] v;
            v = 15'((k * 2731 + 97) & 16'h7FFF);
            if (k == 46) v = 15'h7FFF;
            if (k == 47) v = 15'h0000;
            bus_start();
            send_byte(8'hC2);
            put_freq(v);
            bus_stop();
            chk(ctrl_now() == exp_ctrl, "R4 control untouched by frequency", ctrl_now(), exp_ctrl);
        end

        // R5 control and port sweep
        for (int k = 0; k < 128; k++) begin
            logic [7:0] p;
            p = 8'((k * 73 + 11) & 8'hFF);
            if (k == 127) p = 8'hFF;
            put_ctrl(8'hC2, 7'(k), p);
            chk(div_ratio == exp_div, "R5 divider untouched by control", div_ratio, exp_div);
        end

        // R6 long stream: freq, ctrl, freq, ctrl, freq without re-address
        bus_start();
        send_byte(8'hC2);
        put_freq(15'h1234);
        send_byte(8'hD5); chk(ctrl_now() == 7'h55, "R6 control in stream", ctrl_now(), 7'h55);
        send_byte(8'hA6); chk(port == 8'hA6, "R6 port in stream", port, 8'hA6);
        put_freq(15'h6ABC);
        put_freq(15'h0F0F);
        send_byte(8'h80); chk(ctrl_now() == 7'h00, "R6 second control", ctrl_now(), 0);
        send_byte(8'h5B); chk(port == 8'h53, "R6 second port", port, 8'h53);
        bus_stop();
        exp_ctrl = 7'h00; exp_port = 8'h53;

        // R10 divider changes exactly at ninth rising edge
        bus_start();
        send_byte(8'hC2);
        send_byte(8'h2A);
        tok = 1'b1;
        send_bits(8'h55, 8);
        sda_m = 1'b1; tick(W);
        chk(div_ratio == exp_div, "R10 divider before ninth edge", div_ratio, exp_div);
        scl_m = 1'b1; tick(W);
        chk(div_ratio == 15'h2A55, "R10 divider after ninth edge", div_ratio, 15'h2A55);
        scl_m = 1'b0; tick(W);
        bus_stop();
        exp_div = 15'h2A55;

        // R7 stop in the middle of a control byte
        bus_start();
        send_byte(8'hC2);
        tok = 1'b1;
        send_bits(8'hFF, 5);
        bus_stop();
        chk(ctrl_now() == exp_ctrl, "R7 partial byte ignored", ctrl_now(), exp_ctrl);
        // R7 stop between the two frequency bytes
        bus_start();
        send_byte(8'hC2);
        send_byte(8'h11);
        bus_stop();
        chk(div_ratio == exp_div, "R7 lone upper byte", div_ratio, exp_div);
        bus_start();
        send_byte(8'hC2);
        send_byte(8'h22);
        bus_stop();
        chk(div_ratio == exp_div, "R7 new transfer reselects pair", div_ratio, exp_div);
        chk(port == exp_port, "R7 port untouched", port, exp_port);

        // R8 repeated start after a mismatched address
        bus_start();
        send_byte(8'hC6);
        chk(ak == 1'b0, "R8 wrong address nack", ak, 0);
        bus_start();
        send_byte(8'hC2);
        chk(ak == 1'b1, "R8 address after repeated start", ak, 1);
        send_byte(8'hB3);
        chk(ctrl_now() == 7'h33, "R8 control after repeated start", ctrl_now(), 7'h33);
        // R8 repeated start in mid-byte
        send_bits(8'h00, 3);
        bus_start();
        send_byte(8'hC2);
        send_byte(8'hC4);
        chk(ctrl_now() == 7'h44, "R8 mid-byte restart", ctrl_now(), 7'h44);
        // R8 repeated start with wrong address blocks data
        bus_start();
        send_byte(8'hC0);
        send_byte(8'hFF);
        chk(ak == 1'b0, "R8 data after mismatch nack", ak, 0);
        bus_stop();
        chk(ctrl_now() == 7'h44, "R8 control kept after mismatch", ctrl_now(), 7'h44);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule